// File: doc/BRIEF.md
# Operand Address Resolver

The resolver takes one instruction's addressing information and produces the operand and its effective address (EA). The inputs are a 4-bit mode code, an address field A, a register selector R and the current program counter. The resolver reads register contents through a combinational register-file port. It makes as many sequential reads on a memory read port as the mode requires, then presents the operand and EA as one result. Address arithmetic wraps modulo 2^AW. A memory word is a pointer when it is used as an address: its low AW bits give the address and its top bit (bit DW-1) asks for one more level of indirection. AW must be less than DW.

Requests enter over a valid/ready handshake. `req_ready` is high only while the unit is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The register selected by `req_rsel` is sampled in that same cycle. Memory reads leave over a valid/ready request channel. Once raised, `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen high. At most one read is outstanding at a time. The single-beat response (`mem_rsp_valid`) cannot be stalled. The result is presented with `res_valid` and held unchanged until `res_ready` is high at a clock edge. No new request is taken before that edge.

Top module: `ea_resolver`

## Requirements
- R1: Mode 0 (immediate) gives operand = A zero-extended, EA = A, and makes no memory read.
- R2: Mode 3 (register) gives operand = full contents of register R, EA = 0, and makes no memory read.
- R3: Modes 1 (direct), 4 (register indirect), 5 (displacement) and 6 (PC-relative) make exactly one memory read and return the word at EA as operand. EA is A, low AW bits of R, A + R, and A + PC respectively, modulo 2^AW.
- R4: Mode 2 (indirect) follows the pointer chain that starts at address A. EA is the low AW bits of the final pointer. The operand is the word at EA, and the read count is (pointer levels + 1).
- R5: Mode 7 (pre-index) follows the pointer chain that starts at address (A + R) mod 2^AW. EA is the final pointer, and the operand is the word at EA.
- R6: Mode 8 (post-index) follows the pointer chain that starts at A. EA is (final pointer + R) mod 2^AW, and the operand is the word at EA.
- R7: A pointer word with bit DW-1 set causes one more level, up to MAX_LEVELS = 4 pointer reads. If the 4th pointer word still has bit DW-1 set, the result carries `res_chain_err` = 1 with operand = 0 and EA = 0, after exactly 4 reads. Exactly 4 levels that end on a clear top bit are legal.
- R8: Mode codes 9 to 15 give `res_illegal` = 1, operand = 0 and EA = 0, with no memory read.
- R9: `mem_req_valid` and `mem_req_addr` stay stable while `mem_req_ready` is low. A new read starts only after the previous response has arrived.
- R10: The result stays valid and unchanged until `res_ready`, and `req_ready` is low while a result is pending.
- R11: After reset, `req_ready` = 1, `res_valid` = 0 and `mem_req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_mode | input | 4 | Addressing mode code |
| req_field | input | AW | Address field A |
| req_rsel | input | RW | Register selector R |
| req_pc | input | AW | Current program counter |
| rf_sel | output | RW | Register file read select |
| rf_data | input | DW | Register file read data (combinational) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | DW | Read data |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed |
| res_operand | output | DW | Operand value |
| res_ea | output | AW | Effective address |
| res_illegal | output | 1 | Mode code was unused |
| res_chain_err | output | 1 | Indirection exceeded the level limit |

## Verification
The bench walks every mode code against address fields at both ends of the address space, across all registers. This catches carry loss: a unit that fails to wrap A + R or A + PC, or that leaks bits of the register above AW into the sum, reports a wrong EA. Pointer chains of three levels, of exactly four levels, and of four levels with the top bit still set separate a limit that is off by one: such a design either flags a legal four-level chain or makes a fifth read. Post-index chains also catch a unit that adds R to the intermediate pointers instead of only the last one. Memory back-pressure and late responses are mixed in, so a unit that drops its request or counts reads wrongly shows a wrong read count or operand.

// File: rtl/ea_resolver_pkg.sv
package ea_resolver_pkg;

  typedef enum logic [3:0] {
    AM_IMM   = 4'd0,
    AM_DIR   = 4'd1,
    AM_IND   = 4'd2,
    AM_REG   = 4'd3,
    AM_RIND  = 4'd4,
    AM_DISP  = 4'd5,
    AM_PCREL = 4'd6,
    AM_PRE   = 4'd7,
    AM_POST  = 4'd8
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR_REQ,
    ST_PTR_WAIT,
    ST_OPR_REQ,
    ST_OPR_WAIT,
    ST_DONE
  } seq_e;

  // Per-mode control derived from the mode code
  typedef struct packed {
    logic legal;        // code is assigned
    logic no_mem;       // result formed without any read
    logic opnd_is_reg;  // operand is the register value
    logic chain;        // mode walks a pointer chain
    logic post_add;     // add R after the chain
    logic start_reg;    // start address is the register
    logic add_reg;      // add register to the start address
    logic add_pc;       // add PC to the start address
  } mode_ctl_t;

endpackage

// File: rtl/ear_mode_decode.sv
module ear_mode_decode
  import ea_resolver_pkg::*;
(
  input  logic [3:0] mode,
  output mode_ctl_t  ctl
);

  always_comb begin
    ctl = '0;
    ctl.legal = 1'b1;
    case (mode)
      AM_IMM:   ctl.no_mem = 1'b1;
      AM_DIR:   ;
      AM_IND:   ctl.chain = 1'b1;
      AM_REG: begin
        ctl.no_mem      = 1'b1;
        ctl.opnd_is_reg = 1'b1;
      end
      AM_RIND:  ctl.start_reg = 1'b1;
      AM_DISP:  ctl.add_reg = 1'b1;
      AM_PCREL: ctl.add_pc = 1'b1;
      AM_PRE: begin
        ctl.chain   = 1'b1;
        ctl.add_reg = 1'b1;
      end
      AM_POST: begin
        ctl.chain    = 1'b1;
        ctl.post_add = 1'b1;
      end
      default:  ctl.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/ear_wrap_adder.sv
module ear_wrap_adder #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] lhs,
  input  logic [AW-1:0] rhs,
  output logic [AW-1:0] sum
);

  // Carry out of the top bit is discarded: modulo 2^AW
  assign sum = lhs + rhs;

endmodule

// File: rtl/ear_level_counter.sv
module ear_level_counter #(
  parameter int MAX_LEVELS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic at_last
);

  localparam int CW = $clog2(MAX_LEVELS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_LEVELS - 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count_q <= '0;
    else if (clear) count_q <= '0;
    else if (step)  count_q <= count_q + 1'b1;
  end

  // The response being taken now is the final permitted level
  assign at_last = (count_q == LAST);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(MAX_LEVELS)) else $error("level count beyond limit"); // R7

endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import ea_resolver_pkg::*;
#(
  parameter int DW         = 16,
  parameter int AW         = 8,
  parameter int RW         = 3,
  parameter int MAX_LEVELS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_mode,
  input  logic [AW-1:0] req_field,
  input  logic [RW-1:0] req_rsel,
  input  logic [AW-1:0] req_pc,
  output logic [RW-1:0] rf_sel,
  input  logic [DW-1:0] rf_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_operand,
  output logic [AW-1:0] res_ea,
  output logic          res_illegal,
  output logic          res_chain_err
);

  localparam int EXT = DW - AW;
  localparam int PTR_FLAG = DW - 1;

  seq_e          state_q;
  mode_ctl_t     ctl;
  logic [AW-1:0] addr_q, base_q;
  logic [DW-1:0] opnd_q;
  logic          post_q, ill_q, err_q;
  logic [AW-1:0] add_lhs, add_rhs, add_sum;
  logic [AW-1:0] reg_low, start_lhs, start_rhs;
  logic          accept, ptr_rsp, at_last;

  assign rf_sel    = req_rsel;
  assign reg_low   = rf_data[AW-1:0];
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign ptr_rsp   = (state_q == ST_PTR_WAIT) && mem_rsp_valid;

  ear_mode_decode u_dec (
    .mode (req_mode),
    .ctl  (ctl)
  );

  // One shared adder: start address at accept, post-index at chain end
  assign start_lhs = ctl.start_reg ? reg_low : req_field;
  assign start_rhs = ctl.add_pc  ? req_pc  :
                     ctl.add_reg ? reg_low : '0;

  always_comb begin
    if (state_q == ST_IDLE) begin
      add_lhs = start_lhs;
      add_rhs = start_rhs;
    end else begin
      add_lhs = mem_rsp_data[AW-1:0];
      add_rhs = post_q ? base_q : '0;
    end
  end

  ear_wrap_adder #(.AW(AW)) u_add (
    .lhs (add_lhs),
    .rhs (add_rhs),
    .sum (add_sum)
  );

  ear_level_counter #(.MAX_LEVELS(MAX_LEVELS)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .step    (ptr_rsp),
    .at_last (at_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      base_q  <= '0;
      opnd_q  <= '0;
      post_q  <= 1'b0;
      ill_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            ill_q  <= 1'b0;
            err_q  <= 1'b0;
            opnd_q <= '0;
            post_q <= ctl.post_add;
            base_q <= reg_low;
            if (!ctl.legal) begin
              ill_q   <= 1'b1;
              addr_q  <= '0;
              state_q <= ST_DONE;
            end else if (ctl.no_mem) begin
              addr_q  <= ctl.opnd_is_reg ? '0 : req_field;
              opnd_q  <= ctl.opnd_is_reg ? rf_data : {{EXT{1'b0}}, req_field};
              state_q <= ST_DONE;
            end else begin
              addr_q  <= add_sum;
              state_q <= ctl.chain ? ST_PTR_REQ : ST_OPR_REQ;
            end
          end
        end
        ST_PTR_REQ: if (mem_req_ready) state_q <= ST_PTR_WAIT;
        ST_PTR_WAIT: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_data[PTR_FLAG]) begin
              if (at_last) begin
                err_q   <= 1'b1;
                addr_q  <= '0;
                state_q <= ST_DONE;
              end else begin
                addr_q  <= mem_rsp_data[AW-1:0];
                state_q <= ST_PTR_REQ;
              end
            end else begin
              addr_q  <= add_sum;
              state_q <= ST_OPR_REQ;
            end
          end
        end
        ST_OPR_REQ: if (mem_req_ready) state_q <= ST_OPR_WAIT;
        ST_OPR_WAIT: begin
          if (mem_rsp_valid) begin
            opnd_q  <= mem_rsp_data;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (state_q == ST_PTR_REQ) || (state_q == ST_OPR_REQ);
  assign mem_req_addr  = addr_q;
  assign res_valid     = (state_q == ST_DONE);
  assign res_operand   = opnd_q;
  assign res_ea        = addr_q;
  assign res_illegal   = ill_q;
  assign res_chain_err = err_q;

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr))
    else $error("memory request dropped or changed"); // R9

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_operand) && $stable(res_ea)
      && $stable(res_illegal) && $stable(res_chain_err))
    else $error("result changed before taken"); // R10

  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready) else $error("request taken while result pending"); // R10

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_illegal && res_chain_err)) else $error("both error flags"); // R7

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_illegal || res_chain_err) |-> res_operand == '0 && res_ea == '0)
    else $error("fault result not zero"); // R8

endmodule

// File: tb/ea_resolver_test.sv
module ea_resolver_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int RW = 3;
  localparam int MAXL = 4;
  localparam int MSZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [3:0]    req_mode = '0;
  logic [AW-1:0] req_field = '0;
  logic [RW-1:0] req_rsel = '0;
  logic [AW-1:0] req_pc = '0;
  logic [RW-1:0] rf_sel;
  logic [DW-1:0] rf_data;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [DW-1:0] res_operand;
  logic [AW-1:0] res_ea;
  logic          res_illegal;
  logic          res_chain_err;

  int compared = 0;
  int mismatched = 0;
  int rd_count = 0;
  int txn_id = 0;
  logic [DW-1:0] mem_img [MSZ];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] regval(input int s);
    return DW'(s * 16'h1111 + 16'h0203);
  endfunction

  assign rf_data = regval(int'(rf_sel));

  ea_resolver #(.DW(DW), .AW(AW), .RW(RW), .MAX_LEVELS(MAXL)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_field(req_field), .req_rsel(req_rsel), .req_pc(req_pc),
    .rf_sel(rf_sel), .rf_data(rf_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_operand(res_operand),
    .res_ea(res_ea), .res_illegal(res_illegal), .res_chain_err(res_chain_err)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h (txn %0d)", tag, what, act, exp, txn_id);
    end
  endtask

  // Memory responder with back-pressure and variable latency
  initial begin
    int cyc = 0;
    bit pend = 0;
    int dly = 0;
    logic [AW-1:0] paddr = '0;
    forever begin
      @(posedge clk);
      if (mem_rsp_valid) mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        rd_count++;
        pend = 1;
        paddr = mem_req_addr;
        dly = int'(mem_req_addr) % 3 + cyc % 2;
      end else if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem_img[paddr];
          pend = 0;
        end else dly--;
      end
      mem_req_ready <= (cyc % 4) != 1;
      cyc++;
    end
  end

  // Walk a pointer chain from the requirements (R4, R7)
  task automatic chase(input logic [AW-1:0] start, output logic [AW-1:0] ptr,
                       output int lv, output bit err);
    logic [AW-1:0] a = start;
    err = 0; ptr = '0; lv = 0;
    for (int l = 1; l <= MAXL; l++) begin
      logic [DW-1:0] w = mem_img[a];
      lv = l;
      if (!w[DW-1]) begin ptr = w[AW-1:0]; return; end
      if (l == MAXL) begin err = 1; return; end
      a = w[AW-1:0];
    end
  endtask

  task automatic run_txn(input int mode, input int a, input int r, input int pc);
    logic [AW-1:0] av = AW'(a);
    logic [AW-1:0] rl = regval(r)[AW-1:0];
    logic [AW-1:0] eea = '0, ptr;
    logic [DW-1:0] eop = '0;
    int n = 0, lv;
    bit eill = 0, eerr = 0, err;
    string tag;
    case (mode)
      0: begin tag = "R1"; eea = av; eop = DW'(av); end
      1: begin tag = "R3"; eea = av; n = 1; end
      3: begin tag = "R2"; eop = regval(r); end
      4: begin tag = "R3"; eea = rl; n = 1; end
      5: begin tag = "R3"; eea = av + rl; n = 1; end
      6: begin tag = "R3"; eea = av + AW'(pc); n = 1; end
      2, 7, 8: begin
        tag = (mode == 2) ? "R4" : (mode == 7) ? "R5" : "R6";
        chase((mode == 7) ? av + rl : av, ptr, lv, err);
        if (err) begin tag = "R7"; eerr = 1; n = MAXL; end
        else begin eea = (mode == 8) ? ptr + rl : ptr; n = lv + 1; end
      end
      default: begin tag = "R8"; eill = 1; end
    endcase
    if (n > 0 && !eerr) eop = mem_img[eea];
    txn_id++;
    @(negedge clk);
    req_mode = 4'(mode); req_field = av; req_rsel = RW'(r); req_pc = AW'(pc);
    req_valid = 1'b1; rd_count = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    repeat (txn_id % 3) @(negedge clk);
    check("R10", "valid held", int'(res_valid), 1);
    check("R10", "ready low while pending", int'(req_ready), 0);
    check(tag, "operand", int'(res_operand), int'(eop));
    check(tag, "ea", int'(res_ea), int'(eea));
    check(tag, "illegal", int'(res_illegal), int'(eill));
    check(tag, "chain_err", int'(res_chain_err), int'(eerr));
    check(tag, "reads", rd_count, n);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    compared++;
    mismatched++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int alist[7] = '{8'h00, 8'h01, 8'h3C, 8'h7F, 8'h80, 8'hFE, 8'hFF};
    for (int i = 0; i < MSZ; i++) mem_img[i] = DW'((i * 37 + 11) & 16'h7FFF);
    repeat (3) @(negedge clk);
    check("R11", "req_ready", int'(req_ready), 1);
    check("R11", "res_valid", int'(res_valid), 0);
    check("R11", "mem_req_valid", int'(mem_req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "idle after release", int'(req_ready), 1);

    // Sweep all mode codes, edge addresses, all registers (R1-style tags per mode)
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 7; k++)
        for (int r = 0; r < (1 << RW); r++)
          run_txn(m, alist[k], r, (alist[k] * 3 + r * 29) & 8'hFF);

    // Three-level chain (R4), and via pre/post index (R5, R6)
    mem_img[8'h10] = 16'h8020; mem_img[8'h20] = 16'h8030; mem_img[8'h30] = 16'h0040;
    run_txn(2, 8'h10, 0, 0);
    run_txn(7, 8'h0D, 0, 0);
    run_txn(8, 8'h10, 2, 0);
    run_txn(8, 8'h10, 7, 0);
    // Exactly four levels is legal (R7)
    mem_img[8'h50] = 16'h8060; mem_img[8'h60] = 16'h8070;
    mem_img[8'h70] = 16'h8088; mem_img[8'h88] = 16'h0099;
    run_txn(2, 8'h50, 0, 0);
    run_txn(8, 8'h50, 5, 0);
    // Fourth pointer still flagged: chain error (R7)
    mem_img[8'h88] = 16'h80AA;
    run_txn(2, 8'h50, 0, 0);
    run_txn(7, 8'h4D, 0, 0);
    run_txn(8, 8'h50, 3, 0);
    finish_run();
  end

endmodule